// File: doc/BRIEF.md
# Serial EEPROM Page Write Buffer and Cycle Timer

This block is the write half of a two-wire serial EEPROM slave. The protocol engine loads a start address once the byte address has been received, then hands over every data byte of the transaction with a one-cycle strobe. The block keeps these bytes in a 16-entry page buffer, with a valid bit for each entry. After each accepted byte, only the low four bits of the address counter step forward. A transaction of more than 16 bytes therefore wraps inside the page and overwrites entries it stored earlier.

Nothing reaches the array while the bytes arrive. A stop strobe that follows at least one stored byte starts a self-timed program cycle. The cycle lasts `WR_CYCLES` system clocks. During the first 16 of those clocks the valid entries are written to the array through a simple write port, one entry per clock. For the whole cycle `busy` is high, so the protocol engine withholds the acknowledge of its slave address, and a host can poll for completion with that acknowledge.

A write-protect input guards the upper half of the array. While it is high, data bytes aimed at that half are refused and signalled as not to be acknowledged. Nothing is stored, and the stop that ends the transaction starts no cycle.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset `busy` and `mem_we` are 0, `cur_addr` is 0, and `data_ack_ok` is 1 while `wp_in` is 0.
- R2: While not busy, an `addr_ld` strobe sets `cur_addr` to `addr_in` in the next cycle.
- R3: Each accepted byte increments `cur_addr[3:0]` modulo 16 in the next cycle and leaves `cur_addr[10:4]` unchanged.
- R4: When more than 16 bytes arrive in one transaction, the last byte received for an offset is the one that is written. Each offset is written at most once per cycle.
- R5: No array write happens before the stop. A stop strobe that follows at least one stored byte raises `busy` in the next cycle, and `busy` then stays high for exactly `WR_CYCLES` cycles.
- R6: Writes happen only while `busy` is high and only to offsets that were received. They go to `{page, offset}` in ascending offset order, and the other bytes of the page keep their contents.
- R7: A stop with no data byte after the address load, as in a dummy write, leaves `busy` low and writes nothing.
- R8: While `busy` is high, `data_ack_ok` is 0 and `addr_ld`, `byte_stb` and `stop_stb` have no effect on `cur_addr`, the buffer or the array.
- R9: With `wp_in` = 1 and `cur_addr[10]` = 1, `data_ack_ok` is 0. A byte strobe then stores nothing and does not move `cur_addr`, and the following stop starts no cycle.
- R10: With `wp_in` = 1 the lower half (`cur_addr[10]` = 0) is still written. With `wp_in` = 0 the upper half is written too.
- R11: When a cycle ends, `cur_addr` points one past the last byte received, with the offset wrapped, and the buffer is empty, so a later stop with no data starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_in | input | 1 | Write protect for the upper half of the array |
| addr_ld | input | 1 | Strobe: load start address |
| addr_in | input | 11 | Start address {block[2:0], word[7:0]} |
| byte_stb | input | 1 | Strobe: one data byte received |
| byte_in | input | 8 | Received data byte |
| stop_stb | input | 1 | Strobe: stop condition seen |
| busy | output | 1 | Program cycle in progress; slave address not acknowledged |
| data_ack_ok | output | 1 | A data byte at this moment would be acknowledged |
| cur_addr | output | 11 | Address counter |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 11 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
Address and buffer effects are due one clock after their strobe. The bench drives each strobe on a falling edge and reads `cur_addr` at the next falling edge, after the single capturing rising edge. `busy` is due in the cycle after the stop strobe and is counted on falling edges until it drops; the count must equal `WR_CYCLES`. `data_ack_ok` is combinational and is read in the same half-cycle as the input that sets it. Array writes are captured on rising edges into a bench memory and a write log, so write order and contents are compared only after `busy` has fallen.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } slot_t;

    typedef enum logic {
        TS_IDLE = 1'b0,
        TS_PROG = 1'b1
    } tmr_state_t;

    function automatic logic is_protected(input logic wp, input logic upper_half);
        return wp & upper_half;
    endfunction
endpackage

// File: rtl/pwb_addr_ctr.sv
module pwb_addr_ctr #(
    parameter int ADDR_W = 11,
    parameter int OFS_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - OFS_W;

    logic [HI_W-1:0]  page_q;
    logic [OFS_W-1:0] ofs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            ofs_q  <= '0;
        end else if (ld) begin
            page_q <= ld_addr[ADDR_W-1:OFS_W];
            ofs_q  <= ld_addr[OFS_W-1:0];
        end else if (step) begin
            ofs_q  <= ofs_q + OFS_W'(1);
        end
    end

    assign addr = {page_q, ofs_q};

    // R3: a step moves only the offset, modulo the page size
    assert_page_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !ld) |=> (addr[ADDR_W-1:OFS_W] == $past(addr[ADDR_W-1:OFS_W]) &&
                           addr[OFS_W-1:0] == $past(addr[OFS_W-1:0]) + OFS_W'(1)))
        else $error("page offset did not wrap correctly");
endmodule

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
    parameter int OFS_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [OFS_W-1:0]     wr_ofs,
    input  pwb_pkg::byte_t       wr_data,
    input  logic [OFS_W-1:0]     rd_ofs,
    output pwb_pkg::slot_t       rd_slot,
    output logic                 any_valid
);
    localparam int PAGE_BYTES = 1 << OFS_W;

    logic [PAGE_BYTES-1:0] vmask;
    pwb_pkg::byte_t        dat [PAGE_BYTES];

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                vmask[i] <= 1'b0;
            end else if (wr_en && wr_ofs == OFS_W'(i)) begin
                vmask[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                dat[i] <= '0;
            end else if (wr_en && wr_ofs == OFS_W'(i)) begin
                dat[i] <= wr_data;
            end
        end
    end

    assign rd_slot.valid = vmask[rd_ofs];
    assign rd_slot.data  = dat[rd_ofs];
    assign any_valid     = |vmask;

    // R11: a clear empties the buffer
    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (rst)
        clr |=> !any_valid)
        else $error("buffer not empty after clear");
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
    parameter int WR_CYCLES = 2500,
    parameter int OFS_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             commit_win,
    output logic [OFS_W-1:0] commit_idx
);
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam int CNT_W      = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

    pwb_pkg::tmr_state_t state_q;
    logic [CNT_W-1:0]    cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= pwb_pkg::TS_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                pwb_pkg::TS_IDLE: begin
                    cnt_q <= '0;
                    if (start) state_q <= pwb_pkg::TS_PROG;
                end
                default: begin
                    if (cnt_q == LAST) begin
                        state_q <= pwb_pkg::TS_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    assign busy       = (state_q == pwb_pkg::TS_PROG);
    assign done       = busy && (cnt_q == LAST);
    assign commit_win = busy && (int'(cnt_q) < PAGE_BYTES);
    assign commit_idx = cnt_q[OFS_W-1:0];

    // R5: the cycle ends exactly after its last count
    assert_cycle_end_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q == LAST) |=> !busy)
        else $error("program cycle overran");

    // R5: the cycle never ends early
    assert_cycle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q != LAST) |=> busy)
        else $error("program cycle ended early");
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
    parameter int ADDR_W    = 11,
    parameter int OFS_W     = 4,
    parameter int WR_CYCLES = 2500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_in,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [7:0]        byte_in,
    input  logic              stop_stb,
    output logic              busy,
    output logic              data_ack_ok,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam int HI_W = ADDR_W - OFS_W;

    logic             accept, load, start, clear, done, any_valid, commit_win;
    logic [OFS_W-1:0] commit_idx;
    pwb_pkg::slot_t   rd_slot;

    assign data_ack_ok = !busy && !pwb_pkg::is_protected(wp_in, cur_addr[ADDR_W-1]);
    assign accept      = byte_stb && data_ack_ok;
    assign load        = addr_ld && !busy;
    assign start       = stop_stb && !busy && any_valid;
    assign clear       = load || done;

    pwb_addr_ctr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) addr_ctr_i (
        .clk(clk), .rst(rst), .ld(load), .ld_addr(addr_in),
        .step(accept), .addr(cur_addr)
    );

    pwb_page_buf #(.OFS_W(OFS_W)) page_buf_i (
        .clk(clk), .rst(rst), .clr(clear), .wr_en(accept),
        .wr_ofs(cur_addr[OFS_W-1:0]), .wr_data(byte_in),
        .rd_ofs(commit_idx), .rd_slot(rd_slot), .any_valid(any_valid)
    );

    pwb_cycle_timer #(.WR_CYCLES(WR_CYCLES), .OFS_W(OFS_W)) timer_i (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .commit_win(commit_win), .commit_idx(commit_idx)
    );

    assign mem_we    = commit_win && rd_slot.valid;
    assign mem_addr  = {cur_addr[ADDR_W-1:ADDR_W-HI_W], commit_idx};
    assign mem_wdata = rd_slot.data;

    // R5: busy only rises in response to a stop
    assert_busy_from_stop_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_stb))
        else $error("busy rose without a stop");

    // R6: the array is only written inside a program cycle
    assert_no_write_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_we)
        else $error("array written outside a program cycle");

    // R7: a stop with an empty buffer starts nothing
    assert_dummy_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (stop_stb && !busy && !any_valid) |=> !busy)
        else $error("cycle started with an empty buffer");

    // R8: the address counter is frozen during a cycle
    assert_busy_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cur_addr))
        else $error("address moved during a program cycle");

    // R9: a protected byte does not move the counter
    assert_protect_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (wp_in && cur_addr[ADDR_W-1] && byte_stb && !addr_ld && !busy) |=> $stable(cur_addr))
        else $error("protected byte was accepted");
endmodule

// File: tb/eeprom_page_writer_tb_top.sv
module eeprom_page_writer_tb_top;
    localparam int WR  = 40;
    localparam int AW  = 11;
    localparam int WDOG = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wp_in = 1'b0, addr_ld = 1'b0, byte_stb = 1'b0, stop_stb = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0] byte_in = '0;
    logic busy, data_ack_ok, mem_we;
    logic [AW-1:0] cur_addr, mem_addr;
    logic [7:0] mem_wdata;

    int checks = 0, errors = 0, cycles = 0;
    logic [7:0] mem [2048];
    logic [7:0] exp_mem [2048];
    logic [AW-1:0] wlog [32];
    int wlog_n = 0;

    always #2 clk = ~clk;

    eeprom_page_writer #(.ADDR_W(AW), .OFS_W(4), .WR_CYCLES(WR)) dut_i (
        .clk(clk), .rst(rst), .wp_in(wp_in), .addr_ld(addr_ld), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_in(byte_in), .stop_stb(stop_stb),
        .busy(busy), .data_ack_ok(data_ack_ok), .cur_addr(cur_addr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            if (wlog_n < 32) wlog[wlog_n] <= mem_addr;
            wlog_n <= wlog_n + 1;
        end
    end

    always @(negedge clk) begin
        if (cycles > WDOG) begin
            errors++;
            $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cycles, WDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic load_addr(input logic [AW-1:0] a);
        @(negedge clk); addr_ld = 1'b1; addr_in = a;
        @(negedge clk); addr_ld = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk); byte_stb = 1'b1; byte_in = d;
        @(negedge clk); byte_stb = 1'b0;
    endtask

    task automatic send_stop();
        @(negedge clk); stop_stb = 1'b1;
        @(negedge clk); stop_stb = 1'b0;
    endtask

    task automatic wait_cycle(input string req, input bit expect_busy);
        int n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk(n == (expect_busy ? WR : 0), req, n, expect_busy ? WR : 0);
    endtask

    task automatic cmp_mem(input string req);
        int bad = -1;
        for (int a = 0; a < 2048; a++) if (bad < 0 && mem[a] !== exp_mem[a]) bad = a;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, int'(mem[bad]), int'(exp_mem[bad]));
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(mem_we == 1'b0, "R1 mem_we", mem_we, 0);
        chk(cur_addr == '0, "R1 cur_addr", cur_addr, 0);
        chk(data_ack_ok == 1'b1, "R1 data_ack_ok", data_ack_ok, 1);
    endtask

    task automatic t_byte_write();
        load_addr(11'h123);
        chk(cur_addr == 11'h123, "R2 load", cur_addr, 'h123);
        send_byte(8'hA7);
        chk(cur_addr == 11'h124, "R3 step", cur_addr, 'h124);
        wlog_n = 0;
        send_stop();
        chk(busy == 1'b1, "R5 busy after stop", busy, 1);
        wait_cycle("R5 cycle length", 1'b1);
        exp_mem[11'h123] = 8'hA7;
        cmp_mem("R6 single byte");
        chk(wlog_n == 1, "R6 write count", wlog_n, 1);
        chk(cur_addr == 11'h124, "R11 pointer after cycle", cur_addr, 'h124);
    endtask

    task automatic t_wrap();
        load_addr(11'h25E);
        for (int i = 0; i < 5; i++) begin
            send_byte(8'h10 + 8'(i));
            exp_mem[{7'h25, 4'(4'hE + 4'(i))}] = 8'h10 + 8'(i);
        end
        chk(cur_addr == 11'h253, "R3 wrap offset", cur_addr, 'h253);
        wlog_n = 0;
        send_stop();
        wait_cycle("R5 cycle length wrap", 1'b1);
        cmp_mem("R6 wrapped page");
        chk(wlog_n == 5, "R6 write count wrap", wlog_n, 5);
        chk(wlog[0] == 11'h250 && wlog[3] == 11'h25E, "R6 ascending order", wlog[3], 'h25E);
    endtask

    task automatic t_overflow();
        load_addr(11'h300);
        wlog_n = 0;
        for (int i = 0; i < 20; i++) begin
            send_byte(8'h80 + 8'(i));
            exp_mem[11'h300 + 11'(i % 16)] = 8'h80 + 8'(i);
        end
        chk(wlog_n == 0, "R5 no write before stop", wlog_n, 0);
        send_stop();
        wait_cycle("R5 cycle length overflow", 1'b1);
        cmp_mem("R4 overwrite keeps last byte");
        chk(wlog_n == 16, "R4 one write per offset", wlog_n, 16);
        chk(cur_addr == 11'h304, "R11 pointer after wrap", cur_addr, 'h304);
    endtask

    task automatic t_dummy();
        load_addr(11'h777);
        wlog_n = 0;
        send_stop();
        chk(busy == 1'b0, "R7 dummy write no busy", busy, 0);
        repeat (20) @(negedge clk);
        chk(wlog_n == 0, "R7 dummy write no writes", wlog_n, 0);
        chk(cur_addr == 11'h777, "R2 dummy pointer", cur_addr, 'h777);
    endtask

    task automatic t_busy_ignore();
        load_addr(11'h040);
        send_byte(8'h3C);
        exp_mem[11'h040] = 8'h3C;
        send_stop();
        chk(data_ack_ok == 1'b0, "R8 no ack while busy", data_ack_ok, 0);
        load_addr(11'h500);
        chk(cur_addr == 11'h041, "R8 load ignored", cur_addr, 'h041);
        send_byte(8'hEE);
        chk(cur_addr == 11'h041, "R8 byte ignored", cur_addr, 'h041);
        send_stop();
        while (busy) @(negedge clk);
        wlog_n = 0;
        repeat (WR + 5) @(negedge clk);
        chk(busy == 1'b0, "R8 stop ignored", busy, 0);
        chk(wlog_n == 0, "R11 no second commit", wlog_n, 0);
        cmp_mem("R8 array untouched");
        wlog_n = 0;
        send_stop();
        chk(busy == 1'b0, "R11 empty buffer after cycle", busy, 0);
    endtask

    task automatic t_protect();
        wp_in = 1'b1;
        load_addr(11'h456);
        chk(data_ack_ok == 1'b0, "R9 upper half refused", data_ack_ok, 0);
        send_byte(8'h99);
        chk(cur_addr == 11'h456, "R9 byte ignored", cur_addr, 'h456);
        wlog_n = 0;
        send_stop();
        chk(busy == 1'b0, "R9 no cycle", busy, 0);
        repeat (20) @(negedge clk);
        cmp_mem("R9 array untouched");
        load_addr(11'h0A0);
        chk(data_ack_ok == 1'b1, "R10 lower half open", data_ack_ok, 1);
        send_byte(8'h5B);
        exp_mem[11'h0A0] = 8'h5B;
        send_stop();
        wait_cycle("R10 lower half cycle", 1'b1);
        wp_in = 1'b0;
        load_addr(11'h7F0);
        chk(data_ack_ok == 1'b1, "R10 upper open without wp", data_ack_ok, 1);
        send_byte(8'hC4);
        exp_mem[11'h7F0] = 8'hC4;
        send_stop();
        wait_cycle("R10 upper half cycle", 1'b1);
        cmp_mem("R10 writes landed");
    endtask

    initial begin
        for (int a = 0; a < 2048; a++) begin
            mem[a] = 8'(a) ^ 8'h5A;
            exp_mem[a] = 8'(a) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_byte_write();
        t_wrap();
        t_overflow();
        t_dummy();
        t_busy_ignore();
        t_protect();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule